// File: doc/BRIEF.md
# Run-Time Page-Size Flash Address Translator

This block maps virtual addresses from an external-flash cache path onto physical flash addresses. It keeps a table of 256 mapping entries. A 2-bit setting chooses the page size, and that setting can change while the chip runs. The page size sets how many low address bits pass straight through and how many select a table entry. It also sets where the instruction window ends and the data window begins.

Software reaches the table only through a small register port. One register selects an entry. A second register reads or writes the entry selected by the first. A third register holds the page-size code.

On the lookup side, a request strobe carries a virtual address and a span. The span is the number of bytes beyond the first one. One cycle later the block returns one of two results:
- a translated physical address and the entry's sensitive flag, with the hit flag set; or
- the error flag, when the request leaves a window or lands on an invalid entry.

Top module: `flash_xlate_mmu`

## Requirements
- R1: After reset the page-size code reads 0, the index register reads 0, every entry reads 0 (invalid), and `rsp_vld` is low.
- R2: Configuration select 0 holds the page-size code in bits [1:0]. Code 0 gives 64 KB pages, 1 gives 32 KB, 2 gives 16 KB and 3 gives 8 KB. The code reads back as written.
- R3: Select 1 is the entry index, in bits [7:0]. Select 2 is the entry content. Writing select 2 stores `cfg_wdata` into the entry named by the index register. Reading select 2 returns that entry.
- R4: Entry bits [8:0] are the physical page number. Bit 9 is valid, where 1 means valid. Bit 10 is sensitive. Select 3 reads 0, and writes to it change nothing.
- R5: The instruction window starts at 0x4200_0000 and covers 128 pages, served by entries 0 to 127. The data window follows directly, covers 128 pages, and is served by entries 128 to 255. Both limits move with the page size.
- R6: The entry index is the virtual address ANDed with (page bytes × 256 − 1), then shifted right by 16, 15, 14 or 13 bits for codes 0 to 3.
- R7: On a hit, the physical address is the page number shifted left by the page shift, ORed with the page-offset bits of the virtual address.
- R8: A request is in range only when its first byte (`req_vaddr`) and its last byte (`req_vaddr + req_span`) both lie in the same window. Any other request returns `rsp_err`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R9: A request that lands on an entry with bit 9 clear, including an all-zero entry, returns `rsp_err`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R10: On a hit, `rsp_sens` equals bit 10 of the matched entry. On an error it is 0.
- R11: The result appears on the clock edge after the one that samples `req_vld`, with `rsp_vld`=1 for exactly that cycle. When `rsp_vld` is 0, `rsp_hit`, `rsp_err`, `rsp_sens` and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 page size, 1 index, 2 entry content, 3 reserved |
| cfg_wdata | input | 11 | Configuration write data |
| cfg_rdata | output | 11 | Read data of the selected register (combinational) |
| req_vld | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the first byte |
| req_span | input | 16 | Bytes after the first byte (last byte = vaddr + span) |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_err | output | 1 | Out of region or invalid entry |
| rsp_sens | output | 1 | Sensitive flag of the matched entry |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
For every page-size code, the bench fills all 256 entries and reads each one back. It then translates one address in every page, so a wrong shift or mask shows up as a wrong page number or a garbled offset. Near each window limit it places requests on both sides: the last byte of the instruction window, a two-byte request that straddles into the data window, the last byte of the data window, the byte after it, and a request whose end wraps past 32 bits. An off-by-one compare or a window limit that ignores the page size would give a hit where an error is due, or the reverse. Entries that are all zero or have bit 9 clear must return errors, so a design with the valid polarity inverted fails at once.

// File: rtl/fmmu_pkg.sv
package fmmu_pkg;

  localparam int unsigned PPN_W = 9;

  typedef struct packed {
    logic             sens;
    logic             vld;
    logic [PPN_W-1:0] ppn;
  } map_entry_t;

  localparam int unsigned ENTRY_W = $bits(map_entry_t);

  typedef enum logic [1:0] {
    SEL_PGSZ  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_RSVD  = 2'd3
  } cfg_sel_e;

  // Page shift for a given code: largest page shift minus the code.
  function automatic logic [5:0] pg_shift(input logic [5:0] max_shift, input logic [1:0] code);
    return max_shift - {4'd0, code};
  endfunction

endpackage

// File: rtl/fmmu_cfg.sv
module fmmu_cfg
  import fmmu_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CFG_W = ENTRY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [1:0]       pgsz,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output map_entry_t       tbl_wdata,
  input  map_entry_t       tbl_rdata
);

  logic [1:0]       pgsz_q;
  logic [IDX_W-1:0] idx_q;
  cfg_sel_e         sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgsz_q <= 2'd0;
      idx_q  <= '0;
    end else if (cfg_we) begin
      if (sel == SEL_PGSZ)  pgsz_q <= cfg_wdata[1:0];
      if (sel == SEL_INDEX) idx_q  <= cfg_wdata[IDX_W-1:0];
    end
  end

  assign pgsz      = pgsz_q;
  assign tbl_idx   = idx_q;
  assign tbl_we    = cfg_we && (sel == SEL_ENTRY);
  assign tbl_wdata = map_entry_t'(cfg_wdata[ENTRY_W-1:0]);

  always_comb begin
    unique case (sel)
      SEL_PGSZ:  cfg_rdata = CFG_W'(pgsz_q);
      SEL_INDEX: cfg_rdata = CFG_W'(idx_q);
      SEL_ENTRY: cfg_rdata = CFG_W'(tbl_rdata);
      default:   cfg_rdata = '0;
    endcase
  end

  p_index_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel == SEL_INDEX) |=> (tbl_idx == $past(cfg_wdata[IDX_W-1:0])));

  p_pgsz_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && sel == SEL_PGSZ) |=> $stable(pgsz));

endmodule

// File: rtl/fmmu_table.sv
module fmmu_table
  import fmmu_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_entry_t       wr_data,
  output map_entry_t       cfg_rd,
  input  logic [IDX_W-1:0] lk_idx,
  output map_entry_t       lk_rd
);

  map_entry_t mem [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))  mem[g] <= wr_data;
    end
  end

  assign cfg_rd = mem[wr_idx];
  assign lk_rd  = mem[lk_idx];

  p_entry_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/fmmu_lookup.sv
module fmmu_lookup
  import fmmu_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 32,
  parameter int unsigned    SPAN_W    = 16,
  parameter int unsigned    IDX_W     = 8,
  parameter int unsigned    MAX_SHIFT = 16,
  parameter logic [31:0]    WIN_BASE  = 32'h4200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pgsz,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [SPAN_W-1:0] req_span,
  output logic [IDX_W-1:0]  lk_idx,
  input  map_entry_t        lk_ent,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic              rsp_sens,
  output logic [ADDR_W-1:0] rsp_paddr
);

  localparam int unsigned XW   = ADDR_W + 2;
  localparam int unsigned HALF = (1 << IDX_W) / 2;

  logic [5:0]    shamt;
  logic [XW-1:0] pg_bytes, half_bytes, win_lo, win_mid, win_hi;
  logic [XW-1:0] first_b, last_b, tbl_mask;
  logic          in_iwin, in_dwin, region_ok, look_ok;
  logic [ADDR_W-1:0] paddr_d;

  assign shamt      = pg_shift(6'(MAX_SHIFT), pgsz);
  assign pg_bytes   = XW'(1) << shamt;
  assign half_bytes = pg_bytes << (IDX_W - 1);
  assign win_lo     = XW'(WIN_BASE);
  assign win_mid    = win_lo + half_bytes;
  assign win_hi     = win_mid + half_bytes;

  assign first_b = XW'(req_vaddr);
  assign last_b  = first_b + XW'(req_span);

  assign in_iwin   = (first_b >= win_lo)  && (last_b < win_mid);
  assign in_dwin   = (first_b >= win_mid) && (last_b < win_hi);
  assign region_ok = in_iwin || in_dwin;

  assign tbl_mask = (pg_bytes << IDX_W) - XW'(1);
  assign lk_idx   = IDX_W'((first_b & tbl_mask) >> shamt);

  assign look_ok = region_ok && lk_ent.vld;
  assign paddr_d = ADDR_W'((XW'(lk_ent.ppn) << shamt) | (first_b & (pg_bytes - XW'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_sens  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_hit   <= req_vld && look_ok;
      rsp_err   <= req_vld && !look_ok;
      rsp_sens  <= req_vld && look_ok && lk_ent.sens;
      rsp_paddr <= (req_vld && look_ok) ? paddr_d : '0;
    end
  end

  p_iwin_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_iwin |-> (int'(lk_idx) < HALF));

  p_dwin_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_dwin |-> (int'(lk_idx) >= HALF));

  p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!rsp_hit && !rsp_err && !rsp_sens && rsp_paddr == '0));

  p_hit_xor_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_hit ^ rsp_err));

  p_sens_on_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sens |-> rsp_hit);

  p_err_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_paddr == '0));

endmodule

// File: rtl/flash_xlate_mmu.sv
module flash_xlate_mmu
  import fmmu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SPAN_W    = 16,
  parameter int unsigned ENTRIES   = 256,
  parameter int unsigned MAX_SHIFT = 16,
  parameter logic [31:0] WIN_BASE  = 32'h4200_0000,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned CFG_W    = ENTRY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [SPAN_W-1:0] req_span,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic              rsp_sens,
  output logic [ADDR_W-1:0] rsp_paddr
);

  logic [1:0]       pgsz;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [IDX_W-1:0] lk_idx;
  map_entry_t       tbl_wdata, tbl_rdata, lk_ent;

  fmmu_cfg #(.IDX_W(IDX_W), .CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pgsz      (pgsz),
    .tbl_we    (tbl_we),
    .tbl_idx   (tbl_idx),
    .tbl_wdata (tbl_wdata),
    .tbl_rdata (tbl_rdata)
  );

  fmmu_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_wdata),
    .cfg_rd  (tbl_rdata),
    .lk_idx  (lk_idx),
    .lk_rd   (lk_ent)
  );

  fmmu_lookup #(
    .ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .IDX_W(IDX_W),
    .MAX_SHIFT(MAX_SHIFT), .WIN_BASE(WIN_BASE)
  ) u_lk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pgsz      (pgsz),
    .req_vld   (req_vld),
    .req_vaddr (req_vaddr),
    .req_span  (req_span),
    .lk_idx    (lk_idx),
    .lk_ent    (lk_ent),
    .rsp_vld   (rsp_vld),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .rsp_sens  (rsp_sens),
    .rsp_paddr (rsp_paddr)
  );

endmodule

// File: tb/sim_flash_xlate_mmu.sv
module sim_flash_xlate_mmu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam longint BASE   = 64'h4200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [10:0] cfg_wdata = '0;
  logic [10:0] cfg_rdata;
  logic        req_vld = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [15:0] req_span = '0;
  logic        rsp_vld, rsp_hit, rsp_err, rsp_sens;
  logic [31:0] rsp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] bm [256];
  int cur_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_xlate_mmu u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_vld(req_vld), .req_vaddr(req_vaddr), .req_span(req_span),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_sens(rsp_sens), .rsp_paddr(rsp_paddr)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [10:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [10:0] d);
    cfg_we = 1'b0; cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic put_entry(input int i, input logic [10:0] v);
    cfg_wr(2'd1, 11'(i));
    cfg_wr(2'd2, v);
    bm[i] = v;
  endtask

  function automatic logic [10:0] pat(input int i, input int code);
    logic [8:0] p;
    logic v, s;
    if (i % 64 == 10) return 11'd0;
    p = 9'((i*37 + code*53 + 5) % 512);
    v = ((i*5 + code) % 9) != 4;
    s = 1'(((i >> 1) ^ code) & 1);
    return {s, v, p};
  endfunction

  // Reference translation written from the requirements.
  task automatic model(input longint va, input longint span, input int code,
                       output logic hit, output logic sens, output longint pa);
    longint pg, win, off, wf, wl, e;
    logic [10:0] ent;
    pg  = longint'(65536) >> code;
    win = pg * 128;
    off = va - BASE;
    hit = 1'b0; sens = 1'b0; pa = 0;
    if (off < 0) return;
    wf = off / win;
    wl = (off + span) / win;
    if (wf != wl || wf > 1) return;
    e = off / pg;
    ent = bm[e];
    if (!ent[9]) return;
    hit  = 1'b1;
    sens = ent[10];
    pa   = longint'(ent[8:0]) * pg + (off % pg);
  endtask

  task automatic lookup(input string tag, input longint va, input longint span);
    logic eh, es;
    longint ep;
    model(va, span, cur_code, eh, es, ep);
    @(negedge clk);
    req_vld = 1'b1; req_vaddr = 32'(va); req_span = 16'(span);
    @(negedge clk);
    req_vld = 1'b0;
    check({tag, " R11 vld"}, rsp_vld, 1);
    check({tag, " R8 R9 hit"}, rsp_hit, eh);
    check({tag, " R8 R9 err"}, rsp_err, !eh);
    check({tag, " R10 sens"}, rsp_sens, es);
    check({tag, " R6 R7 paddr"}, rsp_paddr, ep);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=done", WATCHDOG);
    summary();
  end

  initial begin
    logic [10:0] rd;
    longint pg;
    for (int i = 0; i < 256; i++) bm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 rsp_vld", rsp_vld, 0);
    cfg_rd(2'd0, rd); check("R1 pgsz", rd, 0);
    cfg_rd(2'd1, rd); check("R1 index", rd, 0);
    cfg_rd(2'd2, rd); check("R1 entry0", rd, 0);
    cfg_wr(2'd1, 11'd200);
    cfg_rd(2'd2, rd); check("R1 entry200", rd, 0);
    lookup("R1 first", BASE, 0);

    // R4 reserved select
    cfg_wr(2'd3, 11'h7FF);
    cfg_rd(2'd3, rd); check("R4 rsvd read", rd, 0);
    cfg_rd(2'd0, rd); check("R4 rsvd pgsz", rd, 0);
    cfg_rd(2'd1, rd); check("R4 rsvd index", rd, 200);

    for (int code = 0; code < 4; code++) begin
      cur_code = code;
      pg = longint'(65536) >> code;
      cfg_wr(2'd0, 11'(code));
      cfg_rd(2'd0, rd); check("R2 pgsz readback", rd, code);
      for (int i = 0; i < 256; i++) put_entry(i, pat(i, code));
      for (int i = 0; i < 256; i++) begin
        cfg_wr(2'd1, 11'(i));
        cfg_rd(2'd2, rd); check("R3 R4 entry readback", rd, bm[i]);
      end
      // R5 R6 R7: one address in every page of both windows
      for (int i = 0; i < 256; i++) begin
        longint off, span;
        off  = longint'((i*7919 + code*131) % int'(pg));
        span = (i % 4 == 0) ? pg - 1 : longint'(i % 5);
        lookup("R5 sweep", BASE + longint'(i)*pg + off, span);
      end
      // R8 boundaries; force entries 127 and 255 valid
      put_entry(127, {1'b1, 1'b1, 9'h155});
      put_entry(255, {1'b0, 1'b1, 9'h0AA});
      put_entry(128, {1'b1, 1'b1, 9'h1FF});
      lookup("R8 below base", BASE - 1, 0);
      lookup("R8 last instr byte", BASE + 128*pg - 1, 0);
      lookup("R8 instr end pair", BASE + 128*pg - 2, 1);
      lookup("R8 straddle", BASE + 128*pg - 1, 1);
      lookup("R5 data first", BASE + 128*pg, 0);
      lookup("R8 last data byte", BASE + 256*pg - 1, 0);
      lookup("R8 past data", BASE + 256*pg, 0);
      lookup("R8 wrap", 64'hFFFF_FFF0, 16'h0020);
      // R9 entry rewritten to zero becomes invalid
      put_entry(128, 11'd0);
      lookup("R9 zeroed", BASE + 128*pg + 3, 0);
    end

    // R11 idle after a response
    @(negedge clk);
    check("R11 idle vld", rsp_vld, 0);
    check("R11 idle paddr", rsp_paddr, 0);
    summary();
  end

endmodule